// File: doc/BRIEF.md
# Keyed-Halt Watchdog Timer

This block is a watchdog timer on a small register bus. It leaves reset already running, counts up once per clock from a programmable reload value and, when the count passes all-ones, raises a one-cycle reset request and reloads. Firmware that does not want the watchdog must halt it on purpose. To do that it writes an ordered pair of key words to a control register. A different ordered pair restarts it.

Every write to the control register is posted. The write is captured, and a pending flag stays up for a fixed number of clock cycles while the value crosses into the timer logic. The value takes effect on the cycle the flag drops. Software must poll the flag between key writes. A control write that arrives while the flag is still up is discarded.

Reads are combinational from the byte address. The live count is at 0x28, the reload value at 0x2C, the pending status at 0x34 and the control register at 0x48. Reset is asynchronous and active low. Its release is re-timed through a short synchronizer chain.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control register reads 0, the reload register reads 0xFFFFFF00, the status register reads 0, and the watchdog is running.
- R2: While running, the count at offset 0x28 increases by exactly one per clock, and a read returns the live value.
- R3: When a running count is 0xFFFFFFFF, the next edge reloads it from the reload register and drives `wdt_rst_o` high for exactly one cycle. The expiry period is therefore 2^32 minus the reload value.
- R4: The reload register at offset 0x2C is readable and writable. A new value is used only at the next reload and leaves the running count untouched.
- R5: A write to the control register (offset 0x48) makes bit 4 (value 0x10) of the status register (offset 0x34) read 1 for exactly 4 cycles after the write edge. The written value takes effect on the edge at which that bit returns to 0.
- R6: The control register reads back the last write it accepted.
- R7: A control write issued while bit 4 of the status register is 1 is discarded. It changes neither the readback nor the key sequence.
- R8: Two accepted control writes, 0x0000AAAA followed directly by 0x00005555, halt the counter. The counter then holds its value and no expiry pulse occurs.
- R9: 0x00005555 that does not directly follow an accepted 0x0000AAAA leaves the watchdog running and clears the sequence. Any value that is not one of the four keys also clears a partial sequence.
- R10: Two accepted control writes, 0x0000BBBB followed directly by 0x00004444, restart a halted counter from its held value. 0x00004444 on its own has no effect.
- R11: The internal logic leaves reset on the second rising clock edge after `rst_n` rises. The count after edge N (counted from the release) is therefore 0xFFFFFF00 + N − 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| wdt_rst_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 4-cycle posting delay, a two-stage reset synchronizer and a reset reload of 0xFFFFFF00. With that reload value, the first expiry falls 256 cycles after reset, so both the out-of-reset expiry and a second full period can be observed directly.

Programming the reload register to 0xFFFFFF80 halves the period. This shows that a new reload value is picked up only at the next wrap. It also leaves room between pulses to run the halt, bad-sequence, dropped-write and restart scenarios. Each expected pulse edge is predicted from the write edges that the bench itself drives.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_COUNT = 8'h28;
  localparam logic [REG_AW-1:0] OFS_LOAD  = 8'h2C;
  localparam logic [REG_AW-1:0] OFS_PEND  = 8'h34;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h48;

  localparam int unsigned PEND_BIT = 4;

  localparam logic [15:0] KEY_HALT_A = 16'hAAAA;
  localparam logic [15:0] KEY_HALT_B = 16'h5555;
  localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN_B  = 16'h4444;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALT1 = 2'd1,
    KS_RUN1  = 2'd2
  } key_st_e;
endpackage

// File: rtl/wdog_rst_sync.sv
`timescale 1ns/1ps
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_post_sync.sv
`timescale 1ns/1ps
module wdog_post_sync #(
  parameter int unsigned DW  = 32,
  parameter int unsigned DLY = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] data_q, data_d;
  logic          accept;

  // a write is taken only when nothing is in flight
  assign accept = wr_i && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    data_d = data_q;
    if (accept) begin
      cnt_d  = CW'(DLY);
      data_d = wdata_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      data_q <= data_d;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CW'(1));
  assign data_o   = data_q;
endmodule

// File: rtl/wdog_key_fsm.sv
`timescale 1ns/1ps
module wdog_key_fsm
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [DW-1:0] key_i,
  output logic          run_o
);
  key_st_e st_q, st_d;
  logic    run_q, run_d;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    if (commit_i) begin
      if (key_i == DW'(KEY_HALT_A)) begin
        st_d = KS_HALT1;
      end else if (key_i == DW'(KEY_HALT_B)) begin
        if (st_q == KS_HALT1) run_d = 1'b0;
        st_d = KS_IDLE;
      end else if (key_i == DW'(KEY_RUN_A)) begin
        st_d = KS_RUN1;
      end else if (key_i == DW'(KEY_RUN_B)) begin
        if (st_q == KS_RUN1) run_d = 1'b1;
        st_d = KS_IDLE;
      end else begin
        st_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= KS_IDLE;
      run_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
  parameter int unsigned  W        = 32,
  parameter logic [W-1:0] LOAD_RST = 32'hFFFF_FF00
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         exp_q, exp_d;
  logic         wrap;

  assign wrap = run_i && (cnt_q == '1);

  always_comb begin
    cnt_d = cnt_q;
    exp_d = wrap;
    if (wrap)       cnt_d = load_i;
    else if (run_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD_RST;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign count_o  = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       SYNC_DLY   = 4,
  parameter int unsigned       RST_STAGES = 2,
  parameter logic [DATA_W-1:0] LOAD_RST   = 32'hFFFF_FF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdt_rst_o
);
  logic              rst_core_n;
  logic              busy, commit, run;
  logic              ctrl_wr, load_wr;
  logic [DATA_W-1:0] ctrl_q, count, load_q, load_d;

  wdog_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_core_n)
  );

  assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
  assign load_wr = reg_we && (reg_addr == OFS_LOAD);

  wdog_post_sync #(.DW(DATA_W), .DLY(SYNC_DLY)) u_post (
    .clk      (clk),
    .rst_ni   (rst_core_n),
    .wr_i     (ctrl_wr),
    .wdata_i  (reg_wdata),
    .busy_o   (busy),
    .commit_o (commit),
    .data_o   (ctrl_q)
  );

  wdog_key_fsm #(.DW(DATA_W)) u_keys (
    .clk      (clk),
    .rst_ni   (rst_core_n),
    .commit_i (commit),
    .key_i    (ctrl_q),
    .run_o    (run)
  );

  wdog_counter #(.W(DATA_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk      (clk),
    .rst_ni   (rst_core_n),
    .run_i    (run),
    .load_i   (load_q),
    .count_o  (count),
    .expire_o (wdt_rst_o)
  );

  // reload register, clock enable written out
  always_comb begin
    load_d = load_q;
    if (load_wr) load_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) load_q <= LOAD_RST;
    else             load_q <= load_d;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_COUNT: reg_rdata = count;
      OFS_LOAD:  reg_rdata = load_q;
      OFS_PEND:  reg_rdata = DATA_W'(busy) << PEND_BIT;
      OFS_CTRL:  reg_rdata = ctrl_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
`timescale 1ns/1ps
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              run,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] load_q,
  input logic              wdt_rst,
  input logic              busy,
  input logic              commit,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] ctrl_q
);
  // R2: a running count below all-ones steps by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && count != '1) |=> (count == $past(count) + DATA_W'(1)));

  // R3: an expiry pulse coincides with the count taking the prior reload value
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    wdt_rst |-> (count == $past(load_q)));

  // R3: the pulse lasts one cycle unless the count wraps again at once
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wdt_rst && count != '1) |=> !wdt_rst);

  // R8: a halted counter holds its value
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> $stable(count));

  // R7: a control write during pending leaves the captured value alone
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && reg_we && reg_addr == OFS_CTRL) |=> $stable(ctrl_q));

  // R5: the pending flag is down right after the value takes effect
  p_commit_clears_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |=> !busy);
endmodule

bind wdog_keyed wdog_keyed_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_core_n),
  .run      (run),
  .count    (count),
  .load_q   (load_q),
  .wdt_rst  (wdt_rst_o),
  .busy     (busy),
  .commit   (commit),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .ctrl_q   (ctrl_q)
);

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;
  import wdog_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic        wdt_rst_o;

  wdog_keyed u_wdog_keyed (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .wdt_rst_o (wdt_rst_o)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t rd_q[$];
  int       pulse_q[$];
  int       cyc;
  int       n_chk;
  int       n_bad;

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: pops expected reads and expected pulse edges
  always @(negedge clk) begin
    if (rd_q.size() > 0) begin
      rd_item_t it;
      it = rd_q.pop_front();
      n_chk++;
      if (reg_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: cycle %0d read %h expected %h", it.tag, cyc, reg_rdata, it.exp);
      end
    end
    if (wdt_rst_o === 1'b1) begin
      n_chk++;
      if (pulse_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3/R8: pulse at cycle %0d expected none", cyc);
      end else begin
        int e;
        e = pulse_q.pop_front();
        if (e != cyc) begin
          n_bad++;
          $display("FAIL R3: pulse at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    rd_q.push_back('{e, tag});
    @(negedge clk);
  endtask

  task automatic cnt_chk(input logic [31:0] base, input int base_cyc, input string tag);
    @(posedge clk); #1;
    reg_addr = OFS_COUNT;
    rd_q.push_back('{base + 32'(cyc - base_cyc), tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int w);
    @(posedge clk); #1;
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    w = cyc + 1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic pend_chk(input int w, input string tag);
    forever begin
      @(posedge clk); #1;
      reg_addr = OFS_PEND;
      rd_q.push_back('{((cyc < w + 4) ? 32'h10 : 32'h0), tag});
      @(negedge clk);
      if (cyc >= w + 4) break;
    end
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): run still going at cycle %0d, expected end before 100000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int          w;
    int          wd;
    int          pe;
    logic [31:0] held;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R3/R11: expiry from the reset reload value, then one full period
    pulse_q.push_back(258);
    pulse_q.push_back(514);

    rd_chk(OFS_CTRL, 32'h0, "R1 ctrl reset");
    rd_chk(OFS_LOAD, 32'hFFFF_FF00, "R1 load reset");
    rd_chk(OFS_PEND, 32'h0, "R1 status reset");
    cnt_chk(32'hFFFF_FF00, 2, "R11 count after release");
    cnt_chk(32'hFFFF_FF00, 2, "R2 live count");

    // R4: new reload value used only at the next wrap
    wait_until(520);
    wr(OFS_LOAD, 32'hFFFF_FF80, w);
    rd_chk(OFS_LOAD, 32'hFFFF_FF80, "R4 load readback");
    cnt_chk(32'hFFFF_FF00, 514, "R4 count untouched by load write");
    pulse_q.push_back(770);
    pulse_q.push_back(898);
    pulse_q.push_back(1026);

    // R9/R7/R6/R5: bad sequences leave it running
    wait_until(1030);
    wr(OFS_CTRL, 32'h5555, w);
    rd_chk(OFS_CTRL, 32'h5555, "R6 ctrl readback");
    pend_chk(w, "R5 pending window");
    wr(OFS_CTRL, 32'hAAAA, w);
    wr(OFS_CTRL, 32'h5555, wd);
    rd_chk(OFS_CTRL, 32'hAAAA, "R7 dropped write readback");
    pend_chk(w, "R7 pending unaffected");
    wr(OFS_CTRL, 32'h1234, w);
    pend_chk(w, "R9 other value");
    wr(OFS_CTRL, 32'h5555, w);
    pend_chk(w, "R9 second key alone");
    cnt_chk(32'hFFFF_FF80, 1026, "R9 still running");
    pulse_q.push_back(1154);
    pulse_q.push_back(1282);

    // R8: proper halt
    wait_until(1290);
    wr(OFS_CTRL, 32'hAAAA, w);
    pend_chk(w, "R5 first key");
    wr(OFS_CTRL, 32'h5555, w);
    pend_chk(w, "R5 second key");
    held = 32'hFFFF_FF80 + 32'(w + 4 - 1282);
    rd_chk(OFS_COUNT, held, "R8 held count");
    wait_until(cyc + 100);
    rd_chk(OFS_COUNT, held, "R8 held count later");
    wait_until(1600);

    // R10: restart
    wr(OFS_CTRL, 32'h4444, w);
    pend_chk(w, "R10 lone restart key");
    wait_until(cyc + 10);
    rd_chk(OFS_COUNT, held, "R10 lone restart key ignored");
    wr(OFS_CTRL, 32'hBBBB, w);
    pend_chk(w, "R10 first restart key");
    wr(OFS_CTRL, 32'h4444, w);
    pend_chk(w, "R10 second restart key");
    cnt_chk(held, w + 4, "R10 resumed from held value");
    pe = w + 5 + int'(32'hFFFF_FFFF - held);
    pulse_q.push_back(pe);
    wait_until(pe + 20);

    n_chk++;
    if (pulse_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3: %0d pulses missing, expected 0", pulse_q.size());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule